// File: doc/BRIEF.md
# Multi-Op Tile Plan Generator

This block turns one composite command into the ordered stage lists that drive a tile pipeline. The descriptor names a head compute operation (matrix multiply or vector math) and up to `MAX_EPI` epilogue operations. Each epilogue has its own compute kind and a firing scope. The descriptor also gives the number of output tiles and the number of K-reduction steps per output tile. The head operation fixes the tile grid: one tile is produced for every (output tile, K step) pair. The tile id advances with the K step fastest.

For each tile the generator streams the stage entries one per accepted handshake. Each entry carries the stage-type code, the id of the component that executes it, the tile id, the entry's position in the plan, the plan length, and flags for the last entry of the plan and the last entry of the kernel. Epilogue stages sit between the head compute and the store, and they appear only on the tiles their scope selects. The generator only builds plans; it executes none of the stages.

Top module: `tile_plan_gen`

## Requirements
- R1: From reset the block is idle, with `busy` and `out_valid` low. A `start` accepted while idle with both counts nonzero raises `busy` and `out_valid` on the next cycle, and the first entry is then on the outputs.
- R2: A `start` with `n_out` or `n_k` equal to zero is dropped: `busy` and `out_valid` stay low.
- R3: Tiles are emitted in id order 0 to `n_out*n_k-1`, where tile id = out_index*`n_k` + k_index. One entry advances per cycle with `out_valid` and `out_ready` both high. While `out_ready` is low the entry is held unchanged.
- R4: Every plan begins with DMA read (code 0), then fetch (code 1), then the head compute, and ends with store (code 4) then DMA write (code 5). The head compute is GEMM (code 2) when `head_is_math`=0 and MATH (code 3) when it is 1.
- R5: Epilogue slot e (0-based) takes part only when e < `epi_count`. Its kind bit `epi_is_math[e]` selects GEMM (2) when 0 and MATH (3) when 1. Epilogue entries that fire follow the head compute in ascending slot order.
- R6: Scope code 0 (field `epi_scope[2e+1:2e]`) fires on every tile.
- R7: Scope code 1 fires only on tiles whose K index is `n_k-1`, that is, the last K step of each output tile.
- R8: Scope code 2 fires only on the final tile of the kernel.
- R9: Scope code 3 never fires.
- R10: With `epi_count`=0 every plan has exactly the five stages of R4.
- R11: `out_comp_id` is `CID_DMA` for codes 0 and 5, `CID_FS` for codes 1 and 4, `CID_GEMM` for code 2 and `CID_MATH` for code 3. The defaults are 0, 1, 2 and 3.
- R12: `out_plan_len` gives the number of entries in the current plan, and `out_stage_idx` counts 0 to `out_plan_len-1`. `out_plan_last` is high on index `out_plan_len-1`. `out_kernel_last` is high only on the last entry of the final tile. `busy` falls in the cycle after that entry is taken.
- R13: While `busy` is high, `start` and all descriptor inputs are ignored, and the running plan stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, taken when idle |
| head_is_math | input | 1 | Head compute kind: 0 GEMM, 1 MATH |
| epi_count | input | $clog2(MAX_EPI+1) | Number of epilogue slots in use |
| epi_is_math | input | MAX_EPI | Per-slot compute kind |
| epi_scope | input | 2*MAX_EPI | Per-slot scope code, 2 bits per slot |
| n_out | input | OUT_W | Output tile count |
| n_k | input | K_W | K-reduction steps per output tile |
| busy | output | 1 | A kernel's plans are being emitted |
| out_valid | output | 1 | Stage entry valid |
| out_ready | input | 1 | Consumer accepts the entry |
| out_tile_id | output | OUT_W+K_W | Tile id of the entry |
| out_stage_idx | output | $clog2(MAX_EPI+5) | Position within the plan |
| out_stage_type | output | 3 | Stage-type code |
| out_comp_id | output | CID_W | Destination component id |
| out_plan_len | output | $clog2(MAX_EPI+6) | Entry count of the current plan |
| out_plan_last | output | 1 | Last entry of this tile's plan |
| out_kernel_last | output | 1 | Last entry of the kernel |

## Verification
On the final tile of a kernel, the per-output-tile, once and per-K scopes can all select epilogues in the same plan. The per-output-tile and once cases land together exactly when the final tile is also a last K step, which is always true for that tile. The bench sweeps every scope combination across one to three slots and grids up to 3x3. For each tile it computes the expected compacted stage list from the scope rules, so an epilogue that is dropped, doubled or put in the wrong order on that shared tile shows up as a stage-type mismatch. A second overlap is the kernel's end meeting a held-high `start`. The bench keeps `start` asserted with scrambled descriptor fields through every run, then checks that `busy` falls and no new stream appears.

// File: rtl/tplan_pkg.sv
package tplan_pkg;
   typedef enum logic [2:0] {
      ST_DMA_RD = 3'd0,
      ST_FETCH  = 3'd1,
      ST_GEMM   = 3'd2,
      ST_MATH   = 3'd3,
      ST_STORE  = 3'd4,
      ST_DMA_WR = 3'd5
   } stage_e;

   typedef enum logic [1:0] {
      SC_PER_K   = 2'd0,
      SC_PER_OUT = 2'd1,
      SC_ONCE    = 2'd2,
      SC_NEVER   = 2'd3
   } scope_e;

   function automatic logic [2:0] compute_code(input logic is_math);
      return is_math ? ST_MATH : ST_GEMM;
   endfunction
endpackage

// File: rtl/tplan_walker.sv
module tplan_walker #(
   parameter int OUT_W = 4,
   parameter int K_W   = 4,
   localparam int TID_W = OUT_W + K_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic [OUT_W-1:0] n_out,
   input  logic [K_W-1:0]   n_k,
   output logic             k_last,
   output logic             tile_last,
   output logic [TID_W-1:0] tile_id
);
   logic [OUT_W-1:0] o_idx;
   logic [K_W-1:0]   k_idx;

   assign k_last    = (k_idx == n_k - K_W'(1));
   assign tile_last = k_last && (o_idx == n_out - OUT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         o_idx   <= '0;
         k_idx   <= '0;
         tile_id <= '0;
      end else if (adv) begin
         tile_id <= tile_id + TID_W'(1);
         if (k_last) begin
            k_idx <= '0;
            o_idx <= o_idx + OUT_W'(1);
         end else begin
            k_idx <= k_idx + K_W'(1);
         end
      end
   end

   a_r3_tile_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !tile_last && !load |=> tile_id == $past(tile_id) + TID_W'(1));
endmodule

// File: rtl/tplan_builder.sv
module tplan_builder
   import tplan_pkg::*;
#(
   parameter int MAX_EPI = 3,
   localparam int LIST  = MAX_EPI + 5,
   localparam int IDX_W = $clog2(LIST),
   localparam int LEN_W = $clog2(LIST + 1),
   localparam int ECW   = $clog2(MAX_EPI + 1)
) (
   input  logic                    head_is_math,
   input  logic [ECW-1:0]          epi_count,
   input  logic [MAX_EPI-1:0]      epi_is_math,
   input  logic [2*MAX_EPI-1:0]    epi_scope,
   input  logic                    k_last,
   input  logic                    tile_last,
   output logic [LIST-1:0][2:0]    lst,
   output logic [LEN_W-1:0]        len
);
   logic [MAX_EPI-1:0] fire;

   for (genvar e = 0; e < MAX_EPI; e++) begin : g_slot
      logic   used;
      scope_e sc;
      assign used = (e < int'(epi_count));
      assign sc   = scope_e'(epi_scope[2*e +: 2]);
      always_comb begin
         unique case (sc)
            SC_PER_K:   fire[e] = used;
            SC_PER_OUT: fire[e] = used && k_last;
            SC_ONCE:    fire[e] = used && tile_last;
            default:    fire[e] = 1'b0;
         endcase
      end
   end

   always_comb begin
      logic [LEN_W-1:0] n;
      lst    = '0;
      lst[0] = ST_DMA_RD;
      lst[1] = ST_FETCH;
      lst[2] = compute_code(head_is_math);
      n      = LEN_W'(3);
      for (int e = 0; e < MAX_EPI; e++) begin
         if (fire[e]) begin
            lst[IDX_W'(n)] = compute_code(epi_is_math[e]);
            n = n + LEN_W'(1);
         end
      end
      lst[IDX_W'(n)]           = ST_STORE;
      lst[IDX_W'(n + LEN_W'(1))] = ST_DMA_WR;
      len = n + LEN_W'(2);
   end

   always_comb begin
      a_r10_len_range: assert (len >= LEN_W'(5) && len <= LEN_W'(LIST));
   end
endmodule

// File: rtl/tplan_emitter.sv
module tplan_emitter #(
   parameter int IDX_W = 3,
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             active,
   input  logic             ready,
   input  logic [LEN_W-1:0] len,
   output logic [IDX_W-1:0] idx,
   output logic             plan_last,
   output logic             hs
);
   assign hs        = active && ready;
   assign plan_last = (LEN_W'(idx) == len - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || load)  idx <= '0;
      else if (hs)         idx <= plan_last ? '0 : idx + IDX_W'(1);
   end

   a_r12_idx_in_plan: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> LEN_W'(idx) < len);
endmodule

// File: rtl/tile_plan_gen.sv
module tile_plan_gen
   import tplan_pkg::*;
#(
   parameter int MAX_EPI  = 3,
   parameter int OUT_W    = 4,
   parameter int K_W      = 4,
   parameter int CID_W    = 4,
   parameter int CID_DMA  = 0,
   parameter int CID_FS   = 1,
   parameter int CID_GEMM = 2,
   parameter int CID_MATH = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          head_is_math,
   input  logic [$clog2(MAX_EPI+1)-1:0]  epi_count,
   input  logic [MAX_EPI-1:0]            epi_is_math,
   input  logic [2*MAX_EPI-1:0]          epi_scope,
   input  logic [OUT_W-1:0]              n_out,
   input  logic [K_W-1:0]                n_k,
   output logic                          busy,
   output logic                          out_valid,
   input  logic                          out_ready,
   output logic [OUT_W+K_W-1:0]          out_tile_id,
   output logic [$clog2(MAX_EPI+5)-1:0]  out_stage_idx,
   output logic [2:0]                    out_stage_type,
   output logic [CID_W-1:0]              out_comp_id,
   output logic [$clog2(MAX_EPI+6)-1:0]  out_plan_len,
   output logic                          out_plan_last,
   output logic                          out_kernel_last
);
   localparam int LIST  = MAX_EPI + 5;
   localparam int IDX_W = $clog2(LIST);
   localparam int LEN_W = $clog2(LIST + 1);
   localparam int ECW   = $clog2(MAX_EPI + 1);

   if (MAX_EPI < 1 || MAX_EPI > 3) begin : g_bad_epi
      $error("tile_plan_gen: MAX_EPI must lie in 1..3");
   end
   if (OUT_W < 1 || K_W < 1 || CID_W < 2) begin : g_bad_width
      $error("tile_plan_gen: count and id widths too small");
   end

   logic                   hm_q;
   logic [ECW-1:0]         ec_q;
   logic [MAX_EPI-1:0]     em_q;
   logic [2*MAX_EPI-1:0]   es_q;
   logic [OUT_W-1:0]       no_q;
   logic [K_W-1:0]         nk_q;

   logic                   accept, k_last, tile_last, plan_last, hs, finish;
   logic [LIST-1:0][2:0]   lst;
   logic [LEN_W-1:0]       len;
   logic [IDX_W-1:0]       idx;

   assign accept = start && !busy && (n_out != '0) && (n_k != '0);
   assign finish = hs && plan_last && tile_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         hm_q <= 1'b0;
         ec_q <= '0;
         em_q <= '0;
         es_q <= '0;
         no_q <= '0;
         nk_q <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         hm_q <= head_is_math;
         ec_q <= epi_count;
         em_q <= epi_is_math;
         es_q <= epi_scope;
         no_q <= n_out;
         nk_q <= n_k;
      end else if (finish) begin
         busy <= 1'b0;
      end
   end

   tplan_walker #(.OUT_W(OUT_W), .K_W(K_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(accept), .adv(hs && plan_last),
      .n_out(no_q), .n_k(nk_q), .k_last(k_last), .tile_last(tile_last),
      .tile_id(out_tile_id)
   );

   tplan_builder #(.MAX_EPI(MAX_EPI)) u_build (
      .head_is_math(hm_q), .epi_count(ec_q), .epi_is_math(em_q),
      .epi_scope(es_q), .k_last(k_last), .tile_last(tile_last),
      .lst(lst), .len(len)
   );

   tplan_emitter #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_emit (
      .clk(clk), .rst_n(rst_n), .load(accept), .active(busy),
      .ready(out_ready), .len(len), .idx(idx), .plan_last(plan_last), .hs(hs)
   );

   assign out_valid       = busy;
   assign out_stage_idx   = idx;
   assign out_stage_type  = lst[idx];
   assign out_plan_len    = len;
   assign out_plan_last   = plan_last;
   assign out_kernel_last = plan_last && tile_last;

   always_comb begin
      unique case (stage_e'(out_stage_type))
         ST_FETCH, ST_STORE: out_comp_id = CID_W'(CID_FS);
         ST_GEMM:            out_comp_id = CID_W'(CID_GEMM);
         ST_MATH:            out_comp_id = CID_W'(CID_MATH);
         default:            out_comp_id = CID_W'(CID_DMA);
      endcase
   end

   a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && n_out != '0 && n_k != '0 |=> busy && out_valid);
   a_r2_zero_drop: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && (n_out == '0 || n_k == '0) |=> !busy);
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_tile_id)
         && $stable(out_stage_idx) && $stable(out_stage_type));
   a_r4_opens_read: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_stage_idx == '0 |-> out_stage_type == ST_DMA_RD);
   a_r4_closes_write: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_plan_last |-> out_stage_type == ST_DMA_WR);
   a_r12_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_kernel_last |=> !busy);
   a_r13_desc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(es_q) && $stable(nk_q) && $stable(no_q));
endmodule

// File: tb/sim_tile_plan_gen.sv
module sim_tile_plan_gen;
   localparam int MAX_EPI = 3;
   localparam int OUT_W   = 4;
   localparam int K_W     = 4;
   localparam int CID_W   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic head_is_math = 1'b0;
   logic [1:0] epi_count = '0;
   logic [2:0] epi_is_math = '0;
   logic [5:0] epi_scope = '0;
   logic [OUT_W-1:0] n_out = '0;
   logic [K_W-1:0] n_k = '0;
   logic out_ready = 1'b0;
   logic busy, out_valid, out_plan_last, out_kernel_last;
   logic [OUT_W+K_W-1:0] out_tile_id;
   logic [2:0] out_stage_idx, out_stage_type;
   logic [CID_W-1:0] out_comp_id;
   logic [3:0] out_plan_len;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   tile_plan_gen u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .head_is_math(head_is_math),
      .epi_count(epi_count), .epi_is_math(epi_is_math), .epi_scope(epi_scope),
      .n_out(n_out), .n_k(n_k), .busy(busy), .out_valid(out_valid),
      .out_ready(out_ready), .out_tile_id(out_tile_id),
      .out_stage_idx(out_stage_idx), .out_stage_type(out_stage_type),
      .out_comp_id(out_comp_id), .out_plan_len(out_plan_len),
      .out_plan_last(out_plan_last), .out_kernel_last(out_kernel_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int comp_of(input int code);
      if (code == 0 || code == 5) return 0;
      if (code == 1 || code == 4) return 1;
      return code;
   endfunction

   task automatic scramble();
      head_is_math = cyc[0];
      epi_count    = 2'(cyc >> 1);
      epi_is_math  = 3'(cyc * 5);
      epi_scope    = 6'(cyc * 11);
      n_out        = 4'(cyc * 3 + 1);
      n_k          = 4'(cyc + 2);
   endtask

   // One kernel: expected plan built from R4..R10, compared at each handshake
   task automatic run(input int hm, input int ne, input int sc, input int km,
                      input int no, input int nk);
      int tt;
      tt = no * nk;
      @(negedge clk);
      head_is_math = 1'(hm); epi_count = 2'(ne); epi_is_math = 3'(km);
      epi_scope = 6'(sc); n_out = 4'(no); n_k = 4'(nk); start = 1'b1;
      out_ready = 1'b0;
      @(negedge clk); cyc++;
      #1 chk(busy === 1'b1 && out_valid === 1'b1, "R1 launch", busy, 1);
      for (int t = 0; t < tt; t++) begin
         int ex [8];
         int n;
         bool_k: begin end
         ex[0] = 0; ex[1] = 1; ex[2] = hm ? 3 : 2; n = 3;
         for (int e = 0; e < ne; e++) begin
            int s;
            bit f;
            s = (sc >> (2 * e)) & 3;
            f = (s == 0) || (s == 1 && (t % nk) == nk - 1) || (s == 2 && t == tt - 1);
            if (f) begin ex[n] = ((km >> e) & 1) ? 3 : 2; n++; end
         end
         ex[n] = 4; ex[n+1] = 5; n = n + 2;
         for (int i = 0; i < n; i++) begin
            bit got;
            got = 0;
            while (!got) begin
               @(negedge clk); cyc++;
               out_ready = ((cyc % 5) != 2);
               start = 1'b1;      // R13: held start and junk descriptor while busy
               scramble();
               #1;
               if (out_valid && out_ready) begin
                  got = 1;
                  chk(out_stage_type == 3'(ex[i]),
                      "R4 R5 R6 R7 R8 R9 R10 R13 stage type", out_stage_type, ex[i]);
                  chk(out_comp_id == 4'(comp_of(ex[i])), "R11 component id",
                      out_comp_id, comp_of(ex[i]));
                  chk(out_tile_id == 8'(t), "R3 tile id", out_tile_id, t);
                  chk(out_stage_idx == 3'(i) && out_plan_len == 4'(n),
                      "R12 index and length", out_stage_idx * 16 + out_plan_len, i * 16 + n);
                  chk(out_plan_last == (i == n - 1) &&
                      out_kernel_last == (i == n - 1 && t == tt - 1),
                      "R12 last flags", out_plan_last * 2 + out_kernel_last,
                      (i == n - 1) * 2 + (i == n - 1 && t == tt - 1));
               end
            end
         end
      end
      @(negedge clk); cyc++;
      start = 1'b0; out_ready = 1'b0;
      #1 chk(busy === 1'b0 && out_valid === 1'b0, "R12 R13 idle after final entry", busy, 0);
   endtask

   task automatic zero_try(input int no, input int nk);
      @(negedge clk);
      n_out = 4'(no); n_k = 4'(nk); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1 chk(busy === 1'b0 && out_valid === 1'b0, "R2 zero count dropped", busy, 0);
      @(negedge clk);
      #1 chk(out_valid === 1'b0, "R2 still idle", out_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 chk(busy === 1'b0 && out_valid === 1'b0, "R1 reset idle", busy, 0);
      rst_n = 1'b1;
      zero_try(0, 2);
      zero_try(3, 0);
      for (int hm = 0; hm < 2; hm++)
         for (int ne = 0; ne <= MAX_EPI; ne++)
            for (int sc = 0; sc < (1 << (2 * ne)); sc++)
               for (int no = 1; no <= 3; no++)
                  for (int nk = 1; nk <= 3; nk++)
                     run(hm, ne, sc, (sc * 3 + hm * 5) & 7, no, nk);
      run(0, 3, 6'b10_01_00, 3'b101, 4, 5);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule